// File: doc/BRIEF.md
# Peripheral Reset and Hibernate Wake Controller

This block holds two small registers behind a simple register bus. The first drives active-high reset lines to four on-module peripherals: the audio/touch codec, the Ethernet PHY, the WLAN radio and the Bluetooth radio. A read of this register does not return the reset bits. It returns the logic version number, which is fixed by a parameter. The second register asks the module to enter hibernation and chooses which events may wake it. Every write is a bitwise update. One address bit decides whether the written ones set bits or clear them, so software never needs a read-modify-write.

The wake events are a touch event, an external power-management wake line, a reset event, and one interrupt pin. The interrupt pin can wake the module either when it is high or when it is low. Each raw wake line passes through a two-flop synchronizer. While hibernation is requested, any enabled source that is active drops the request and produces a one-cycle wake pulse. The reset-event enable only exists when the version is 4 or higher. The low-level interrupt enable only exists when the version is 7 or higher. On an older version these bits stay at zero whatever is written.

Top module: `pwr_rst_ctrl`

## Requirements
- R1: A write with word address bit 0 at 0 sets every register bit whose written data bit is 1. Bits written as 0 keep their value.
- R2: A write with word address bit 0 at 1 clears every register bit whose written data bit is 1. Bits written as 0 keep their value.
- R3: The control register sits at word addresses 0 (set) and 1 (clear). Its data bits 2, 3, 4 and 5 drive `codec_rst`, `phy_rst`, `wlan_rst` and `bt_rst`. Data bits 0, 1, 6 and 7 have no effect on any output.
- R4: A read (`bus_rd`) returns data on `bus_rdata` one cycle later. Reading word address 0 or 1 returns VERSION. Reading any other address returns 0.
- R5: The hibernate register sits at word addresses 2 (set) and 3 (clear). Its data bit 0 drives `hib_req`. Clearing that bit through the bus drops `hib_req` with no wake pulse.
- R6: Hibernate bits 1 to 5 enable these wake sources: bit 1 touch (`touch_evt` high), bit 2 power-management wake (`pmic_wake` high), bit 3 `irq_pin` high, bit 4 `rst_evt` high, bit 5 `irq_pin` low. When `hib_req` is 1 and an enabled source goes active at its raw input, `hib_req` falls and `wake_pulse` is 1 for exactly one cycle. Both happen at the third rising edge after the input change.
- R7: An active wake source whose enable bit is 0 leaves `hib_req` at 1 and `wake_pulse` at 0.
- R8: Hibernate bit 4 can only be set when VERSION >= 4. Bit 5 can only be set when VERSION >= 7. Otherwise writes leave the bit at 0, and the source it would enable never wakes the module.
- R9: After reset, all four reset lines, `hib_req` and `wake_pulse` are 0.
- R10: Writes to word addresses 4 to 7 change no register and no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, data one cycle later |
| bus_addr | input | ADDR_W | Word address; bit 0 picks set (0) or clear (1) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| touch_evt | input | 1 | Raw touch wake event, active high |
| pmic_wake | input | 1 | Raw power-management wake line, active high |
| irq_pin | input | 1 | Raw interrupt pin, level wake either polarity |
| rst_evt | input | 1 | Raw reset wake event, active high |
| codec_rst | output | 1 | Audio/touch codec reset |
| phy_rst | output | 1 | Ethernet PHY reset |
| wlan_rst | output | 1 | WLAN radio reset |
| bt_rst | output | 1 | Bluetooth radio reset |
| hib_req | output | 1 | Hibernate request |
| wake_pulse | output | 1 | One-cycle wake indication |

## Verification
Set and clear writes are applied with patterns that mix used and unused control bits. This separates the two write modes and shows that the unused positions never reach a reset line. Each of the five wake sources is raised with only its own enable set. The bench samples just before and exactly at the third edge, which pins the synchronizer latency and the single-cycle pulse. A source that is active while its enable is clear must not wake the module. A second instance built with version 5 receives the same stimulus. It must keep ignoring the low-level interrupt enable that the version 7 instance honours, and it must report its own version number on a read.

// File: rtl/pwr_rst_pkg.sv
package pwr_rst_pkg;

  localparam int REG_W    = 8;
  localparam int NUM_RAW  = 4;
  localparam int NUM_WAKE = 5;

  // Control register: reset line bit positions
  localparam int CTRL_LSB   = 2;
  localparam int CTRL_W     = 4;
  localparam int CTRL_CODEC = 0;
  localparam int CTRL_PHY   = 1;
  localparam int CTRL_WLAN  = 2;
  localparam int CTRL_BT    = 3;

  // Hibernate register bit positions
  localparam int HIB_W     = 6;
  localparam int HIB_ENTER = 0;
  localparam int WK_TOUCH  = 1;
  localparam int WK_PMIC   = 2;
  localparam int WK_IRQH   = 3;
  localparam int WK_RSTEV  = 4;
  localparam int WK_IRQL   = 5;

  localparam int VER_RSTEV = 4;
  localparam int VER_IRQL  = 7;

  typedef enum logic [1:0] {
    SEL_CTRL  = 2'd0,
    SEL_HIB   = 2'd1,
    SEL_SPARE = 2'd2,
    SEL_VOID  = 2'd3
  } reg_sel_e;

  // Writable hibernate bits for a given logic version
  function automatic logic [HIB_W-1:0] hib_mask(input int version);
    logic [HIB_W-1:0] m;
    m = '1;
    if (version < VER_RSTEV) m[WK_RSTEV] = 1'b0;
    if (version < VER_IRQL)  m[WK_IRQL]  = 1'b0;
    return m;
  endfunction

  // Any source both active and enabled
  function automatic logic wake_any(input logic [NUM_WAKE-1:0] src,
                                    input logic [NUM_WAKE-1:0] en);
    return |(src & en);
  endfunction

endpackage

// File: rtl/wake_sync.sv
module wake_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[s] <= '0;
        else        stg[s] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[s] <= '0;
        else        stg[s] <= stg[s-1];
      end
    end
  end

  assign dout = stg[STAGES-1];

endmodule

// File: rtl/setclr_reg.sv
module setclr_reg #(
  parameter int              WIDTH = 4,
  parameter logic [WIDTH-1:0] MASK = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             clr_mode,
  input  logic [WIDTH-1:0] wdata,
  input  logic [WIDTH-1:0] force_clr,
  output logic [WIDTH-1:0] q
);

  function automatic logic [WIDTH-1:0] setclr_next(
      input logic [WIDTH-1:0] cur,
      input logic [WIDTH-1:0] data,
      input logic             clr);
    logic [WIDTH-1:0] r;
    if (clr) r = cur & ~data;
    else     r = cur | data;
    return r & MASK;
  endfunction

  logic [WIDTH-1:0] nxt;

  always_comb begin
    nxt = q;
    if (wr_en) nxt = setclr_next(q, wdata, clr_mode);
    nxt = nxt & ~force_clr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= nxt;
  end

endmodule

// File: rtl/wake_detect.sv
module wake_detect
  import pwr_rst_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [HIB_W-1:0]    hib_bits,
  input  logic [NUM_WAKE-1:0] src,
  output logic                wake_fire,
  output logic                wake_pulse
);

  logic [NUM_WAKE-1:0] en;

  assign en        = hib_bits[HIB_W-1:WK_TOUCH];
  assign wake_fire = hib_bits[HIB_ENTER] & wake_any(src, en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wake_pulse <= 1'b0;
    else        wake_pulse <= wake_fire;
  end

endmodule

// File: rtl/pwr_rst_ctrl.sv
module pwr_rst_ctrl
  import pwr_rst_pkg::*;
#(
  parameter int VERSION     = 7,
  parameter int ADDR_W      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  input  logic              touch_evt,
  input  logic              pmic_wake,
  input  logic              irq_pin,
  input  logic              rst_evt,
  output logic              codec_rst,
  output logic              phy_rst,
  output logic              wlan_rst,
  output logic              bt_rst,
  output logic              hib_req,
  output logic              wake_pulse
);

  localparam int SEL_W = ADDR_W - 1;
  localparam logic [HIB_W-1:0]  HIB_MASK = hib_mask(VERSION);
  localparam logic [REG_W-1:0]  VER_VAL  = REG_W'(VERSION);

  // Decode
  logic [SEL_W-1:0] sel;
  logic             clr_mode;
  logic             ctrl_we;
  logic             hib_we;
  logic             sel_ctrl;

  assign sel      = bus_addr[ADDR_W-1:1];
  assign clr_mode = bus_addr[0];
  assign sel_ctrl = (sel == SEL_W'(SEL_CTRL));
  assign ctrl_we  = bus_wr && sel_ctrl;
  assign hib_we   = bus_wr && (sel == SEL_W'(SEL_HIB));

  logic unused_wdata_hi;
  assign unused_wdata_hi = ^bus_wdata[REG_W-1:CTRL_LSB+CTRL_W];

  // Control register
  logic [CTRL_W-1:0] ctrl_bits;

  setclr_reg #(.WIDTH(CTRL_W), .MASK({CTRL_W{1'b1}})) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (ctrl_we),
    .clr_mode  (clr_mode),
    .wdata     (bus_wdata[CTRL_LSB +: CTRL_W]),
    .force_clr ({CTRL_W{1'b0}}),
    .q         (ctrl_bits)
  );

  assign codec_rst = ctrl_bits[CTRL_CODEC];
  assign phy_rst   = ctrl_bits[CTRL_PHY];
  assign wlan_rst  = ctrl_bits[CTRL_WLAN];
  assign bt_rst    = ctrl_bits[CTRL_BT];

  // Hibernate register
  logic [HIB_W-1:0] hib_bits;
  logic [HIB_W-1:0] hib_force;
  logic             wake_fire;

  always_comb begin
    hib_force            = '0;
    hib_force[HIB_ENTER] = wake_fire;
  end

  setclr_reg #(.WIDTH(HIB_W), .MASK(HIB_MASK)) u_hib (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (hib_we),
    .clr_mode  (clr_mode),
    .wdata     (bus_wdata[HIB_W-1:0]),
    .force_clr (hib_force),
    .q         (hib_bits)
  );

  assign hib_req = hib_bits[HIB_ENTER];

  // Wake sources
  logic [NUM_RAW-1:0]  raw_in;
  logic [NUM_RAW-1:0]  raw_s;
  logic [NUM_WAKE-1:0] src;

  assign raw_in = {rst_evt, irq_pin, pmic_wake, touch_evt};

  wake_sync #(.WIDTH(NUM_RAW), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (raw_in),
    .dout  (raw_s)
  );

  // src bit i is enabled by hibernate bit i+1
  assign src = {~raw_s[2], raw_s[3], raw_s[2], raw_s[1], raw_s[0]};

  wake_detect u_wake (
    .clk        (clk),
    .rst_n      (rst_n),
    .hib_bits   (hib_bits),
    .src        (src),
    .wake_fire  (wake_fire),
    .wake_pulse (wake_pulse)
  );

  // Read port
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= sel_ctrl ? VER_VAL : '0;
  end

endmodule

// File: rtl/pwr_rst_ctrl_chk.sv
module pwr_rst_ctrl_chk
  import pwr_rst_pkg::*;
#(
  parameter int VERSION = 7,
  parameter int ADDR_W  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [REG_W-1:0]  bus_wdata,
  input logic [REG_W-1:0]  bus_rdata,
  input logic              codec_rst,
  input logic              phy_rst,
  input logic              hib_req,
  input logic              wake_pulse,
  input logic              wake_fire,
  input logic [CTRL_W-1:0] ctrl_bits,
  input logic [HIB_W-1:0]  hib_bits
);

  logic ctrl_access;
  assign ctrl_access = bus_wr && (bus_addr[ADDR_W-1:1] == '0);

  assert_set_mode_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_access && !bus_addr[0] && bus_wdata[CTRL_LSB+CTRL_CODEC] |=> codec_rst);

  assert_clear_mode_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_access && bus_addr[0] && bus_wdata[CTRL_LSB+CTRL_PHY] |=> !phy_rst);

  assert_ctrl_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_access |=> $stable(ctrl_bits));

  assert_version_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd && (bus_addr[ADDR_W-1:1] == '0) |=> bus_rdata == REG_W'(VERSION));

  assert_wake_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wake_fire |=> !hib_req && wake_pulse);

  assert_pulse_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |=> !wake_pulse);

  assert_pulse_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |-> $past(hib_req));

  assert_gated_bits_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (hib_bits & ~hib_mask(VERSION)) == '0);

endmodule

bind pwr_rst_ctrl pwr_rst_ctrl_chk #(.VERSION(VERSION), .ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_wr     (bus_wr),
  .bus_rd     (bus_rd),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .bus_rdata  (bus_rdata),
  .codec_rst  (codec_rst),
  .phy_rst    (phy_rst),
  .hib_req    (hib_req),
  .wake_pulse (wake_pulse),
  .wake_fire  (wake_fire),
  .ctrl_bits  (ctrl_bits),
  .hib_bits   (hib_bits)
);

// File: tb/tb_pwr_rst_ctrl.sv
module tb_pwr_rst_ctrl;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic       touch_evt = 1'b0;
  logic       pmic_wake = 1'b0;
  logic       irq_pin = 1'b0;
  logic       rst_evt = 1'b0;

  logic [7:0] rd7, rd5;
  logic codec7, phy7, wlan7, bt7, hib7, pulse7;
  logic codec5, phy5, wlan5, bt5, hib5, pulse5;

  int vectors = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pwr_rst_ctrl #(.VERSION(7)) dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rd7),
    .touch_evt(touch_evt), .pmic_wake(pmic_wake), .irq_pin(irq_pin),
    .rst_evt(rst_evt), .codec_rst(codec7), .phy_rst(phy7),
    .wlan_rst(wlan7), .bt_rst(bt7), .hib_req(hib7), .wake_pulse(pulse7)
  );

  pwr_rst_ctrl #(.VERSION(5)) dut_v5 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rd5),
    .touch_evt(touch_evt), .pmic_wake(pmic_wake), .irq_pin(irq_pin),
    .rst_evt(rst_evt), .codec_rst(codec5), .phy_rst(phy5),
    .wlan_rst(wlan5), .bt_rst(bt5), .hib_req(hib5), .wake_pulse(pulse5)
  );

  localparam logic [2:0] A_CTRL_SET = 3'd0, A_CTRL_CLR = 3'd1;
  localparam logic [2:0] A_HIB_SET  = 3'd2, A_HIB_CLR  = 3'd3;

  function automatic bit wake_allowed(input int ver, input int hib_bit);
    if (hib_bit == 4) return ver >= 4;
    if (hib_bit == 5) return ver >= 7;
    return 1'b1;
  endfunction

  task automatic check(input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic bus_read(input logic [2:0] a, input string req,
                          input logic [7:0] exp7, input logic [7:0] exp5);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    check(req, "rdata v7", rd7, exp7);
    check(req, "rdata v5", rd5, exp5);
  endtask

  function automatic logic [7:0] rst_vec7();
    return {4'b0, bt7, wlan7, phy7, codec7};
  endfunction

  task automatic t_reset_R9();
    check("R9", "reset lines v7", rst_vec7(), 8'h00);
    check("R9", "reset lines v5", {4'b0, bt5, wlan5, phy5, codec5}, 8'h00);
    check("R9", "hib/pulse", {6'b0, hib7 | hib5, pulse7 | pulse5}, 8'h00);
  endtask

  task automatic t_set_R1();
    bus_write(A_CTRL_SET, 8'h04);
    check("R1", "set codec", rst_vec7(), 8'b0001);
    bus_write(A_CTRL_SET, 8'h28);
    check("R1", "set phy+bt keeps codec", rst_vec7(), 8'b1011);
    bus_write(A_CTRL_SET, 8'hC3);
    check("R3", "unused ctrl bits", rst_vec7(), 8'b1011);
  endtask

  task automatic t_clear_R2();
    bus_write(A_CTRL_CLR, 8'h24);
    check("R2", "clear codec+bt", rst_vec7(), 8'b0010);
    bus_write(A_CTRL_SET, 8'h10);
    check("R3", "wlan line", rst_vec7(), 8'b0110);
    bus_write(A_CTRL_CLR, 8'hC3);
    check("R3", "clear unused bits no effect", rst_vec7(), 8'b0110);
    bus_write(A_CTRL_CLR, 8'hFF);
    check("R2", "clear all", rst_vec7(), 8'b0000);
  endtask

  task automatic t_read_R4();
    bus_read(A_CTRL_SET, "R4", 8'd7, 8'd5);
    bus_read(A_CTRL_CLR, "R4", 8'd7, 8'd5);
    bus_read(A_HIB_SET,  "R4", 8'd0, 8'd0);
    bus_read(3'd6,       "R4", 8'd0, 8'd0);
  endtask

  task automatic t_unused_R10();
    bus_write(3'd4, 8'hFF);
    bus_write(3'd6, 8'hFF);
    check("R10", "reset lines", rst_vec7(), 8'h00);
    check("R10", "hib_req", {7'b0, hib7}, 8'h00);
  endtask

  task automatic t_hib_R5();
    bus_write(A_HIB_SET, 8'h01);
    check("R5", "hib_req set", {6'b0, hib7, hib5}, 8'b11);
    bus_write(A_HIB_CLR, 8'h01);
    check("R5", "hib_req cleared", {6'b0, hib7, hib5}, 8'b00);
    check("R5", "no pulse on bus clear", {6'b0, pulse7, pulse5}, 8'b00);
  endtask

  task automatic drive_src(input int bitn, input logic act);
    case (bitn)
      1: touch_evt = act;
      2: pmic_wake = act;
      3: irq_pin   = act;
      4: rst_evt   = act;
      default: irq_pin = ~act;
    endcase
  endtask

  // en_bit: enable bit written; src_bit: source made active
  task automatic t_wake(input int en_bit, input int src_bit, input string req);
    bit w7, w5;
    w7 = (en_bit == src_bit) && wake_allowed(7, en_bit);
    w5 = (en_bit == src_bit) && wake_allowed(5, en_bit);
    if (src_bit == 5) begin
      @(negedge clk); irq_pin = 1'b1;
      repeat (4) @(negedge clk);
    end
    bus_write(A_HIB_SET, 8'(1 << en_bit) | 8'h01);
    check(req, "hib entered", {6'b0, hib7, hib5}, 8'b11);
    drive_src(src_bit, 1'b1);
    repeat (2) @(negedge clk);
    check(req, "still hibernating before 3rd edge", {6'b0, hib7, hib5}, 8'b11);
    @(negedge clk);
    check(req, "hib_req after wake", {6'b0, hib7, hib5}, {6'b0, ~w7, ~w5});
    check(req, "wake_pulse", {6'b0, pulse7, pulse5}, {6'b0, w7, w5});
    @(negedge clk);
    check(req, "pulse single cycle", {6'b0, pulse7, pulse5}, 8'b00);
    drive_src(src_bit, 1'b0);
    irq_pin = 1'b0;
    repeat (4) @(negedge clk);
    bus_write(A_HIB_CLR, 8'hFF);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_R9();
    t_set_R1();
    t_clear_R2();
    t_read_R4();
    t_unused_R10();
    t_hib_R5();
    t_wake(1, 1, "R6 touch");
    t_wake(2, 2, "R6 pmic");
    t_wake(3, 3, "R6 irq high");
    t_wake(4, 4, "R6 R8 reset event");
    t_wake(5, 5, "R6 R8 irq low");
    t_wake(1, 2, "R7 pmic disabled");
    t_wake(3, 4, "R7 reset event disabled");
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      vectors++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

endmodule